// File: doc/BRIEF.md
# Counter Compare Interrupt Unit

This block holds one free-running counter shared by a group of processors, plus a small timer-interrupt register set for each processor. Each processor gets a compare register, a one-bit compare pending flag, a local mask register and a map register. The map register routes the compare interrupt to one of that processor's interrupt pins. When the counter steps onto a processor's compare value, the pending flag for that processor is set. If the mask allows it and the map routes it, the chosen pin rises. The pending flag stays set until software writes a new compare value.

Software reaches the registers through a simple word bus. Each access carries the index of the processor making it. There are three address regions:

- **Shared region:** configuration, counter and a read-only counter view.
- **Own window:** acts on the requesting processor.
- **Redirected window:** acts on whichever processor the requester's selector register names.

Each output pin is the OR of the externally routed shared interrupt level for that pin and the processor's own routed compare interrupt.

Top module: `cmp_irq_unit`

## Requirements
- R1: After reset the following values hold:
  - local mask reads 0x32 and pending reads 0;
  - the map register reads 0x8000_0000 (route flag set, pin 0);
  - compare reads 0xFFFF_FFFF and the selector reads 0;
  - the counter is 0 and running (configuration bit 0 clear);
  - all pins are low.
- R2: The counter advances by one every cycle while configuration bit 0 (stop) is 0. Writing 1 to that bit freezes the counter; writing 0 resumes it.
- R3: A write to the counter register (offset 0x04) loads the counter only while the counter is stopped. While the counter is running the write has no effect.
- R4: When the counter advances to a value equal to a processor's compare register, bit 1 of that processor's pending register becomes 1. The bit stays 1 until that compare register is written.
- R5: Pin `procPin[p*NUM_PINS+k]` is high when `sharedIrq[p*NUM_PINS+k]` is high. It is also high when all of the following hold:
  - the processor's pending bit 1 is set;
  - mask bit 1 is set;
  - map bit 31 is set;
  - the map pin field (bits 5:0) equals k.
- R6: A compare write (window offset 0x18) loads the new value and clears the pending bit, which lowers the routed pin.
- R7: Mask bits change only through a write-1-to-clear register (offset 0x08) and a write-1-to-set register (offset 0x0C). Only mask bits 5:0 exist; higher data bits have no effect.
- R8: A map write (offset 0x10) whose pin field, bits 5:0, is NUM_PINS or more is ignored and the old mapping remains.
- R9: The selector (offset 0x14) accepts only values below NUM_PROC; other values are ignored. Accesses in the redirected window (base 0x80) act on the selected processor, while the own window (base 0x40) acts on the requester.
- R10: The following reads behave as fixed values:
  - the user counter view (offset 0x0C) returns the counter and ignores writes;
  - the counter upper half (offset 0x08) reads 0;
  - the compare upper half (window offset 0x1C) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; read data is combinational |
| busProc | input | 4 | Index of the requesting processor |
| busAddr | input | 8 | Byte address: bits 7:6 select the region (00 shared, 01 own, 10 redirected), bits 5:0 the offset |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, zero when no read is active |
| sharedIrq | input | NUM_PROC*NUM_PINS | Routed shared interrupt levels per processor pin |
| procPin | output | NUM_PROC*NUM_PINS | Interrupt pin levels per processor |

## Verification
The assertions assume the following about the inputs:
- `sharedIrq` changes only synchronously to `clk`;
- the requester index is below NUM_PROC whenever a write hits a per-processor window, so a compare-write strobe always names a real processor;
- no signal is sampled while reset is high.

The bench drives every input just after a rising edge, uses only processor indices 0 and 1, and makes its counter checks from known stopped values or relative reads. Counter-dependent checks therefore never depend on the absolute cycle count since reset.

// File: rtl/cmpirq_pkg.sv
`timescale 1ns/1ps
package cmpirq_pkg;
  localparam int PROC_IDX_W  = 4;
  localparam int ADDR_W      = 8;
  localparam int PIN_FIELD_W = 6;

  localparam logic [1:0] REGION_SHARED = 2'b00;
  localparam logic [1:0] REGION_LOCAL  = 2'b01;
  localparam logic [1:0] REGION_OTHER  = 2'b10;

  localparam logic [5:0] OFS_CFG      = 6'h00;
  localparam logic [5:0] OFS_CNT      = 6'h04;
  localparam logic [5:0] OFS_CNT_HI   = 6'h08;
  localparam logic [5:0] OFS_USER_CNT = 6'h0C;

  localparam logic [5:0] OFS_PEND     = 6'h00;
  localparam logic [5:0] OFS_MASK     = 6'h04;
  localparam logic [5:0] OFS_MASK_CLR = 6'h08;
  localparam logic [5:0] OFS_MASK_SET = 6'h0C;
  localparam logic [5:0] OFS_MAP      = 6'h10;
  localparam logic [5:0] OFS_SEL      = 6'h14;
  localparam logic [5:0] OFS_CMP      = 6'h18;
  localparam logic [5:0] OFS_CMP_HI   = 6'h1C;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_CFG,
    RD_CNT,
    RD_ZERO,
    RD_PEND,
    RD_MASK,
    RD_MAP,
    RD_SEL,
    RD_CMP
  } rdSel_e;

  typedef struct packed {
    logic                  cfgWr;
    logic                  cntWr;
    logic                  maskSetWr;
    logic                  maskClrWr;
    logic                  mapWr;
    logic                  selWr;
    logic                  cmpWr;
    rdSel_e                rdSel;
    logic [PROC_IDX_W-1:0] target;
  } strobe_t;
endpackage

// File: rtl/cmpirq_ctrl.sv
`timescale 1ns/1ps
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int NUM_PROC = 2,
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                           busWrEn,
  input  logic                           busRdEn,
  input  logic [PROC_IDX_W-1:0]          busProc,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWrData,
  input  logic [NUM_PROC*PROC_IDX_W-1:0] selFlat,
  output strobe_t                        strobe
);
  localparam int SEL_BITS = NUM_PROC * PROC_IDX_W;

  logic [1:0]            region;
  logic [5:0]            ofs;
  logic [PROC_IDX_W-1:0] reqSel;
  logic                  reqOk;
  logic                  winHit;
  logic                  pinOk;
  logic                  selOk;

  assign region = busAddr[ADDR_W-1:ADDR_W-2];
  assign ofs    = busAddr[5:0];

  // Selector of the requesting processor, for the redirected window
  always_comb begin
    reqSel = '0;
    for (int p = 0; p < NUM_PROC; p++) begin
      if (busProc == PROC_IDX_W'(p)) begin
        reqSel = selFlat[p*PROC_IDX_W +: PROC_IDX_W];
      end
    end
  end

  assign reqOk  = busProc < PROC_IDX_W'(NUM_PROC);
  assign winHit = reqOk && (region == REGION_LOCAL || region == REGION_OTHER);
  assign pinOk  = busWrData[PIN_FIELD_W-1:0] < PIN_FIELD_W'(NUM_PINS);
  assign selOk  = busWrData < DATA_W'(NUM_PROC);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.target = (region == REGION_OTHER) ? reqSel : busProc;

    if (busWrEn) begin
      if (region == REGION_SHARED) begin
        case (ofs)
          OFS_CFG: strobe.cfgWr = 1'b1;
          OFS_CNT: strobe.cntWr = 1'b1;
          default: ;
        endcase
      end else if (winHit) begin
        case (ofs)
          OFS_MASK_CLR: strobe.maskClrWr = 1'b1;
          OFS_MASK_SET: strobe.maskSetWr = 1'b1;
          OFS_MAP:      strobe.mapWr     = pinOk;
          OFS_SEL:      strobe.selWr     = selOk;
          OFS_CMP:      strobe.cmpWr     = 1'b1;
          default: ;
        endcase
      end
    end

    if (busRdEn) begin
      if (region == REGION_SHARED) begin
        case (ofs)
          OFS_CFG:      strobe.rdSel = RD_CFG;
          OFS_CNT:      strobe.rdSel = RD_CNT;
          OFS_USER_CNT: strobe.rdSel = RD_CNT;
          OFS_CNT_HI:   strobe.rdSel = RD_ZERO;
          default:      strobe.rdSel = RD_NONE;
        endcase
      end else if (winHit) begin
        case (ofs)
          OFS_PEND:   strobe.rdSel = RD_PEND;
          OFS_MASK:   strobe.rdSel = RD_MASK;
          OFS_MAP:    strobe.rdSel = RD_MAP;
          OFS_SEL:    strobe.rdSel = RD_SEL;
          OFS_CMP:    strobe.rdSel = RD_CMP;
          OFS_CMP_HI: strobe.rdSel = RD_ZERO;
          default:    strobe.rdSel = RD_NONE;
        endcase
      end
    end
  end

  if (SEL_BITS < PROC_IDX_W) begin : g_bad
    initial $display("cmpirq_ctrl: NUM_PROC must be at least 1");
  end
endmodule

// File: rtl/cmpirq_datapath.sv
`timescale 1ns/1ps
module cmpirq_datapath
  import cmpirq_pkg::*;
#(
  parameter int          NUM_PROC   = 2,
  parameter int          NUM_PINS   = 6,
  parameter int          DATA_W     = 32,
  parameter int          MASK_W     = 6,
  parameter int          CMP_BIT    = 1,
  parameter int          STOP_BIT   = 0,
  parameter logic [31:0] RESET_MASK = 32'h32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  strobe_t                        strobe,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_PROC*NUM_PINS-1:0]   sharedIrq,
  output logic [NUM_PROC*PROC_IDX_W-1:0] selFlat,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_PROC*NUM_PINS-1:0]   procPin,
  output logic [DATA_W-1:0]              cntVal,
  output logic                           stopped,
  output logic [NUM_PROC-1:0]            pendVec
);
  localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [DATA_W-1:0]     cntQ;
  logic                  stopQ;
  logic [DATA_W-1:0]     cntInc;

  logic [MASK_W-1:0]     maskQ   [NUM_PROC];
  logic                  pendQ   [NUM_PROC];
  logic                  mapOnQ  [NUM_PROC];
  logic [PIN_IDX_W-1:0]  mapPinQ [NUM_PROC];
  logic [DATA_W-1:0]     cmpQ    [NUM_PROC];
  logic [PROC_IDX_W-1:0] selQ    [NUM_PROC];

  logic [NUM_PROC-1:0]   hit;
  logic [NUM_PROC-1:0]   match;
  logic [NUM_PROC-1:0]   localReq;

  assign cntInc = cntQ + DATA_W'(1);

  // Shared counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ  <= '0;
      stopQ <= 1'b0;
    end else begin
      if (strobe.cfgWr) begin
        stopQ <= wrData[STOP_BIT];
      end
      if (stopQ) begin
        if (strobe.cntWr) begin
          cntQ <= wrData;
        end
      end else begin
        cntQ <= cntInc;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PROC; p++) begin
      hit[p]      = (strobe.target == PROC_IDX_W'(p));
      match[p]    = !stopQ && (cntInc == cmpQ[p]);
      localReq[p] = pendQ[p] && maskQ[p][CMP_BIT] && mapOnQ[p];
    end
  end

  // Per-processor register set
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PROC; p++) begin
        maskQ[p]   <= RESET_MASK[MASK_W-1:0];
        pendQ[p]   <= 1'b0;
        mapOnQ[p]  <= 1'b1;
        mapPinQ[p] <= '0;
        cmpQ[p]    <= '1;
        selQ[p]    <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_PROC; p++) begin
        if (hit[p] && strobe.maskSetWr) begin
          maskQ[p] <= maskQ[p] | wrData[MASK_W-1:0];
        end else if (hit[p] && strobe.maskClrWr) begin
          maskQ[p] <= maskQ[p] & ~wrData[MASK_W-1:0];
        end
        if (hit[p] && strobe.mapWr) begin
          mapOnQ[p]  <= wrData[DATA_W-1];
          mapPinQ[p] <= wrData[PIN_IDX_W-1:0];
        end
        if (hit[p] && strobe.selWr) begin
          selQ[p] <= wrData[PROC_IDX_W-1:0];
        end
        if (hit[p] && strobe.cmpWr) begin
          cmpQ[p]  <= wrData;
          pendQ[p] <= 1'b0;
        end else if (match[p]) begin
          pendQ[p] <= 1'b1;
        end
      end
    end
  end

  // Pin combine: shared level OR routed local compare
  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    assign selFlat[p*PROC_IDX_W +: PROC_IDX_W] = selQ[p];
    assign pendVec[p] = pendQ[p];
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      assign procPin[p*NUM_PINS+k] = sharedIrq[p*NUM_PINS+k] |
        (localReq[p] && (mapPinQ[p] == PIN_IDX_W'(k)));
    end
  end

  // Read mux
  logic [MASK_W-1:0]     tMask;
  logic                  tPend;
  logic                  tMapOn;
  logic [PIN_IDX_W-1:0]  tMapPin;
  logic [DATA_W-1:0]     tCmp;
  logic [PROC_IDX_W-1:0] tSel;

  always_comb begin
    tMask   = '0;
    tPend   = 1'b0;
    tMapOn  = 1'b0;
    tMapPin = '0;
    tCmp    = '0;
    tSel    = '0;
    for (int p = 0; p < NUM_PROC; p++) begin
      if (hit[p]) begin
        tMask   = maskQ[p];
        tPend   = pendQ[p];
        tMapOn  = mapOnQ[p];
        tMapPin = mapPinQ[p];
        tCmp    = cmpQ[p];
        tSel    = selQ[p];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_CFG:  rdData[STOP_BIT] = stopQ;
      RD_CNT:  rdData = cntQ;
      RD_PEND: rdData[CMP_BIT] = tPend;
      RD_MASK: rdData[MASK_W-1:0] = tMask;
      RD_MAP: begin
        rdData[DATA_W-1]      = tMapOn;
        rdData[PIN_IDX_W-1:0] = tMapPin;
      end
      RD_SEL:  rdData[PROC_IDX_W-1:0] = tSel;
      RD_CMP:  rdData = tCmp;
      default: rdData = '0;
    endcase
  end

  assign cntVal  = cntQ;
  assign stopped = stopQ;
endmodule

// File: rtl/cmp_irq_unit.sv
`timescale 1ns/1ps
module cmp_irq_unit
  import cmpirq_pkg::*;
#(
  parameter int NUM_PROC = 2,
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [PROC_IDX_W-1:0]        busProc,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic [DATA_W-1:0]            busRdData,
  input  logic [NUM_PROC*NUM_PINS-1:0] sharedIrq,
  output logic [NUM_PROC*NUM_PINS-1:0] procPin
);
  strobe_t                        strobe;
  logic [NUM_PROC*PROC_IDX_W-1:0] selFlat;
  logic [DATA_W-1:0]              cntVal;
  logic                           stopped;
  logic [NUM_PROC-1:0]            pendVec;

  cmpirq_ctrl #(
    .NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
  ) u_ctrl (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busProc  (busProc),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .selFlat  (selFlat),
    .strobe   (strobe)
  );

  cmpirq_datapath #(
    .NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (busWrData),
    .sharedIrq(sharedIrq),
    .selFlat  (selFlat),
    .rdData   (busRdData),
    .procPin  (procPin),
    .cntVal   (cntVal),
    .stopped  (stopped),
    .pendVec  (pendVec)
  );
endmodule

// File: rtl/cmp_irq_unit_checker.sv
`timescale 1ns/1ps
module cmp_irq_unit_checker
  import cmpirq_pkg::*;
#(
  parameter int NUM_PROC = 2,
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input logic                         clk,
  input logic                         rst,
  input strobe_t                      strobe,
  input logic [DATA_W-1:0]            cntVal,
  input logic                         stopped,
  input logic [NUM_PROC-1:0]          pendVec,
  input logic [NUM_PROC*NUM_PINS-1:0] sharedIrq,
  input logic [NUM_PROC*NUM_PINS-1:0] procPin
);
  AST_RUN_STEPS: assert property (@(posedge clk) disable iff (rst)
    !stopped |=> cntVal == $past(cntVal) + DATA_W'(1)); // R2

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stopped && !strobe.cntWr) |=> $stable(cntVal)); // R3

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sharedIrq == '0 && pendVec == '0) |-> procPin == '0); // R5

  AST_SHARED_PASS: assert property (@(posedge clk) disable iff (rst)
    (sharedIrq & ~procPin) == '0); // R5

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_chk
    logic cmpWrTo;
    assign cmpWrTo = strobe.cmpWr && (strobe.target == PROC_IDX_W'(p));

    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (rst)
      cmpWrTo |=> !pendVec[p]); // R6

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
      (pendVec[p] && !cmpWrTo) |=> pendVec[p]); // R4
  end
endmodule

bind cmp_irq_unit cmp_irq_unit_checker #(
  .NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/cmp_irq_unit_bench.sv
`timescale 1ns/1ps
module cmp_irq_unit_bench;
  localparam int NP = 2;
  localparam int NK = 6;
  localparam int DW = 32;

  localparam logic [7:0] A_CFG    = 8'h00;
  localparam logic [7:0] A_CNT    = 8'h04;
  localparam logic [7:0] A_CNT_HI = 8'h08;
  localparam logic [7:0] A_USER   = 8'h0C;
  localparam logic [7:0] W_OWN    = 8'h40;
  localparam logic [7:0] W_OTHER  = 8'h80;
  localparam logic [7:0] O_PEND   = 8'h00;
  localparam logic [7:0] O_MASK   = 8'h04;
  localparam logic [7:0] O_MCLR   = 8'h08;
  localparam logic [7:0] O_MSET   = 8'h0C;
  localparam logic [7:0] O_MAP    = 8'h10;
  localparam logic [7:0] O_SEL    = 8'h14;
  localparam logic [7:0] O_CMP    = 8'h18;
  localparam logic [7:0] O_CMP_HI = 8'h1C;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            busWrEn = 1'b0;
  logic            busRdEn = 1'b0;
  logic [3:0]      busProc = '0;
  logic [7:0]      busAddr = '0;
  logic [DW-1:0]   busWrData = '0;
  logic [DW-1:0]   busRdData;
  logic [NP*NK-1:0] sharedIrq = '0;
  logic [NP*NK-1:0] procPin;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit sbActive = 0;
  logic [DW-1:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  cmp_irq_unit u_cmp_irq_unit (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busProc(busProc), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .sharedIrq(sharedIrq), .procPin(procPin)
  );

  // Monitor: pops the expected read value and compares
  always @(negedge clk) begin
    if (sbActive) begin
      logic [DW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, busRdData, e);
      end
    end
  end

  task automatic busWrite(input logic [3:0] proc, input logic [7:0] addr,
                          input logic [DW-1:0] data);
    busWrEn = 1'b1; busProc = proc; busAddr = addr; busWrData = data;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [3:0] proc, input logic [7:0] addr,
                            input logic [DW-1:0] exp, input string tag);
    busRdEn = 1'b1; busProc = proc; busAddr = addr;
    expQ.push_back(exp); tagQ.push_back(tag);
    sbActive = 1'b1;
    @(posedge clk); #1;
    busRdEn = 1'b0; sbActive = 1'b0;
  endtask

  task automatic sampleRead(input logic [3:0] proc, input logic [7:0] addr,
                            output logic [DW-1:0] val);
    busRdEn = 1'b1; busProc = proc; busAddr = addr;
    @(negedge clk);
    val = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic checkVal(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                          input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPins(input logic [NP*NK-1:0] exp, input string tag);
    checkVal(DW'(procPin), DW'(exp), tag);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [DW-1:0] v1;
    logic [DW-1:0] v2;
    waitCycles(2);
    // R1: reset values, read while reset is held
    expectRead(0, A_CNT, 32'h0, "R1 counter");
    expectRead(0, A_CFG, 32'h0, "R1 config");
    expectRead(0, W_OWN + O_MASK, 32'h32, "R1 mask");
    expectRead(0, W_OWN + O_PEND, 32'h0, "R1 pending");
    expectRead(1, W_OWN + O_MAP, 32'h8000_0000, "R1 map");
    expectRead(1, W_OWN + O_CMP, 32'hFFFF_FFFF, "R1 compare");
    expectRead(0, W_OWN + O_SEL, 32'h0, "R1 selector");
    checkPins('0, "R1 pins");
    rst = 1'b0;

    // R2: running after reset
    sampleRead(0, A_CNT, v1);
    sampleRead(0, A_CNT, v2);
    checkVal(v2, v1 + 1, "R2 running step");
    busWrite(0, A_CFG, 32'h1);
    expectRead(0, A_CFG, 32'h1, "R2 stop bit");
    sampleRead(0, A_CNT, v1);
    sampleRead(0, A_CNT, v2);
    checkVal(v2, v1, "R2 frozen");

    // R3: write only while stopped
    busWrite(0, A_CNT, 32'h100);
    expectRead(0, A_CNT, 32'h100, "R3 load stopped");
    busWrite(0, A_CFG, 32'h0);
    busWrite(0, A_CNT, 32'h5);
    busWrite(0, A_CFG, 32'h1);
    expectRead(0, A_CNT, 32'h102, "R3 ignored while running");

    // R4/R5: compare match raises pending and routes to pin 0
    busWrite(0, W_OWN + O_CMP, 32'h105);
    busWrite(0, A_CFG, 32'h0);
    checkPins('0, "R5 before match");
    waitCycles(2);
    checkPins('0, "R4 one before match");
    waitCycles(1);
    checkPins(12'h001, "R4 at match");
    expectRead(0, W_OWN + O_PEND, 32'h2, "R4 pending set");
    busWrite(0, A_CFG, 32'h1);
    expectRead(0, W_OWN + O_PEND, 32'h2, "R4 pending held");

    // R5: mask and map routing
    busWrite(0, W_OWN + O_MCLR, 32'h2);
    checkPins('0, "R5 masked");
    expectRead(0, W_OWN + O_PEND, 32'h2, "R5 pending while masked");
    busWrite(0, W_OWN + O_MSET, 32'h2);
    checkPins(12'h001, "R5 unmasked");
    busWrite(0, W_OWN + O_MAP, 32'h8000_0003);
    checkPins(12'h008, "R5 pin 3");
    busWrite(0, W_OWN + O_MAP, 32'h0000_0003);
    checkPins('0, "R5 route flag clear");
    busWrite(0, W_OWN + O_MAP, 32'h8000_0002);
    checkPins(12'h004, "R5 pin 2");

    // R8: out-of-range pin ignored
    busWrite(0, W_OWN + O_MAP, 32'h8000_0007);
    expectRead(0, W_OWN + O_MAP, 32'h8000_0002, "R8 map kept");
    checkPins(12'h004, "R8 pin kept");

    // R6: compare write clears pending
    busWrite(0, W_OWN + O_CMP, 32'h200);
    checkPins('0, "R6 pin dropped");
    expectRead(0, W_OWN + O_PEND, 32'h0, "R6 pending cleared");
    expectRead(0, W_OWN + O_CMP, 32'h200, "R6 compare loaded");

    // R7: set/clear mask limited to bits 5:0
    busWrite(0, W_OWN + O_MSET, 32'hFFFF_FFFF);
    expectRead(0, W_OWN + O_MASK, 32'h3F, "R7 set all");
    busWrite(0, W_OWN + O_MCLR, 32'hFFFF_FFC0);
    expectRead(0, W_OWN + O_MASK, 32'h3F, "R7 high bits no effect");
    busWrite(0, W_OWN + O_MCLR, 32'h3D);
    expectRead(0, W_OWN + O_MASK, 32'h02, "R7 clear");

    // R5: shared source passes through
    sharedIrq = 12'h400;
    #1;
    checkPins(12'h400, "R5 shared proc1 pin4");
    sharedIrq = '0;
    #1;

    // R9: selector and redirected window
    busWrite(0, W_OWN + O_SEL, 32'h1);
    expectRead(0, W_OWN + O_SEL, 32'h1, "R9 selector set");
    busWrite(0, W_OTHER + O_CMP, 32'h1234);
    expectRead(1, W_OWN + O_CMP, 32'h1234, "R9 redirected write");
    expectRead(0, W_OWN + O_CMP, 32'h200, "R9 requester untouched");
    expectRead(0, W_OTHER + O_CMP, 32'h1234, "R9 redirected read");
    busWrite(0, W_OWN + O_SEL, 32'h2);
    expectRead(0, W_OWN + O_SEL, 32'h1, "R9 out-of-range selector");
    expectRead(1, W_OWN + O_SEL, 32'h0, "R9 other selector");

    // R10: read-only user view and upper halves
    sampleRead(0, A_CNT, v1);
    busWrite(0, A_USER, 32'h55);
    sampleRead(0, A_CNT, v2);
    checkVal(v2, v1, "R10 user write ignored");
    expectRead(0, A_USER, v1, "R10 user view");
    expectRead(0, A_CNT_HI, 32'h0, "R10 counter upper");
    expectRead(0, W_OWN + O_CMP_HI, 32'h0, "R10 compare upper");

    waitCycles(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule